// File: doc/BRIEF.md
# Sixteen-Pin Bidirectional I/O Port Pair with Change Listeners

This block holds two 16-pin general-purpose I/O ports that a CPU configures and drives through a small register window, while on-chip peripherals drive the same pins through a second path. Each port has a 32-bit control word that holds a direction bit and a pull-up bit for every pin, packed as pairs. Each port also has a 16-bit CPU data word. The level seen on each pin is resolved from three sources: the CPU drive, the peripheral drive and the pull-up. A pin that nobody drives reads 0 unless its pull-up is enabled.

Up to four listeners can register, each with a 32-bit trigger mask that covers both ports. When a CPU write to a control word or a data word changes the resolved levels of that port, the block pulses a notify strobe for each registered listener whose mask overlaps the changed pins. The new levels of both ports are published with the strobe. A nonzero write to the port-interrupt configuration word is not supported and sets a sticky error flag.

Top module: `dualport_gpio`

## Requirements
- R1: In a control word, bit 2n enables the CPU output drive of pin n and bit 2n+1 enables the pull-up of pin n. The register addresses are 0 = control port A, 1 = data port A, 2 = control port B, 3 = data port B, 4 = interrupt configuration.
- R2: The level of each pin is (cpu_dir AND cpu_data) OR (periph_dir AND periph_data) OR (pull-up AND NOT (cpu_dir OR periph_dir)). The levels are shown on `lines_o` with port A in bits 15:0 and port B in bits 31:16.
- R3: A read of a data address returns the resolved levels of that port, not the stored CPU data. A read of a control address returns the stored control word.
- R4: A CPU write to a control or data address that leaves the resolved levels of that port unchanged produces no notify strobe.
- R5: When such a write changes the levels, every registered listener whose mask half for the written port (bits 15:0 for port A, bits 31:16 for port B) overlaps the changed pins gets a single-cycle strobe on `notify_o` in the cycle after the write. No other listener gets a strobe. In that cycle `notify_lines_o` equals the new levels of both ports.
- R6: A registration request takes the lowest free of the four slots, which `reg_grant` and `reg_slot` report in the same cycle. When all four slots are taken, the request is refused.
- R7: A write of a nonzero value to the interrupt configuration address sets `cfg_err_o`, which stays set until reset. A zero write leaves it clear.
- R8: After reset, every control, data and peripheral-drive register is zero, so all pins read 0. No slot is taken and `cfg_err_o` is 0.
- R9: A peripheral drive update changes the levels but never produces a notify strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 3 | CPU register address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data for `cpu_addr` (combinational) |
| per_we | input | 1 | Peripheral drive update strobe |
| per_sel | input | 1 | Port that the peripheral updates (0 = A, 1 = B) |
| per_dir | input | 16 | Peripheral output enables |
| per_data | input | 16 | Peripheral output values |
| reg_req | input | 1 | Listener registration request |
| reg_mask | input | 32 | Trigger mask (port A in 15:0, port B in 31:16) |
| reg_grant | output | 1 | Request accepted this cycle |
| reg_slot | output | 2 | Slot given to the request |
| lines_o | output | 32 | Resolved levels of both ports |
| notify_o | output | 4 | Per-listener notify strobes |
| notify_lines_o | output | 32 | Levels published with the strobes |
| cfg_err_o | output | 1 | Sticky unsupported-configuration flag |

## Verification
Several properties are checked on every cycle. A strobe only ever follows a CPU write to a port register. The published levels always match the live levels during a strobe. The error flag is set by any nonzero configuration write and then stays set, and a request is never granted while all slots are full. The bench scenarios must show the rest. These are the pin-pair bit mapping and the three-source resolution under mixed drive patterns, the per-listener mask filtering across the two ports, and the silence after writes that leave the levels unchanged or come from the peripheral side.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int unsigned ADDR_W = 3;
    localparam logic [ADDR_W-1:0] ADR_CTRL_A = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_DATA_A = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CTRL_B = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_DATA_B = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_ICFG   = 3'd4;
    localparam int unsigned N_PORTS = 2;
endpackage

// File: rtl/gpio_ctrl_unpack.sv
module gpio_ctrl_unpack #(
    parameter int unsigned PINS = 16
) (
    input  logic [2*PINS-1:0] ctrl_i,
    output logic [PINS-1:0]   dir_o,
    output logic [PINS-1:0]   pull_o
);
    for (genvar n = 0; n < PINS; n++) begin : g_pin
        assign dir_o[n]  = ctrl_i[2*n];
        assign pull_o[n] = ctrl_i[2*n+1];
    end
endmodule

// File: rtl/gpio_line_resolve.sv
module gpio_line_resolve #(
    parameter int unsigned PINS = 16
) (
    input  logic [PINS-1:0] cpu_dir_i,
    input  logic [PINS-1:0] cpu_dat_i,
    input  logic [PINS-1:0] per_dir_i,
    input  logic [PINS-1:0] per_dat_i,
    input  logic [PINS-1:0] pull_i,
    output logic [PINS-1:0] lines_o
);
    logic [PINS-1:0] floating;
    assign floating = ~(cpu_dir_i | per_dir_i);
    assign lines_o  = (cpu_dir_i & cpu_dat_i) | (per_dir_i & per_dat_i) | (floating & pull_i);
endmodule

// File: rtl/gpio_listener_table.sv
module gpio_listener_table #(
    parameter int unsigned SLOTS = 4,
    parameter int unsigned MASKW = 32,
    localparam int unsigned SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_i,
    input  logic [MASKW-1:0]            mask_i,
    output logic                        grant_o,
    output logic [SW-1:0]               slot_o,
    output logic [SLOTS-1:0]            used_o,
    output logic [SLOTS-1:0][MASKW-1:0] mask_o
);
    typedef struct packed {
        logic [SLOTS-1:0]            used;
        logic [SLOTS-1:0][MASKW-1:0] mask;
    } tbl_t;

    tbl_t            st_d, st_q;
    logic            found;
    logic [SW-1:0]   free_idx;

    always_comb begin
        st_d     = st_q;
        found    = 1'b0;
        free_idx = '0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            if (!st_q.used[k]) begin
                found    = 1'b1;
                free_idx = SW'(k);
            end
        end
        if (req_i && found) begin
            st_d.used[free_idx] = 1'b1;
            st_d.mask[free_idx] = mask_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_o = req_i && found;
    assign slot_o  = free_idx;
    assign used_o  = st_q.used;
    assign mask_o  = st_q.mask;
endmodule

// File: rtl/dualport_gpio.sv
module dualport_gpio
    import gpio_port_pkg::*;
#(
    parameter int unsigned PINS      = 16,
    parameter int unsigned LISTENERS = 4,
    localparam int unsigned CW = 2 * PINS,
    localparam int unsigned LW = (LISTENERS > 1) ? $clog2(LISTENERS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_we,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [CW-1:0]        cpu_wdata,
    output logic [CW-1:0]        cpu_rdata,
    input  logic                 per_we,
    input  logic                 per_sel,
    input  logic [PINS-1:0]      per_dir,
    input  logic [PINS-1:0]      per_data,
    input  logic                 reg_req,
    input  logic [CW-1:0]        reg_mask,
    output logic                 reg_grant,
    output logic [LW-1:0]        reg_slot,
    output logic [CW-1:0]        lines_o,
    output logic [LISTENERS-1:0] notify_o,
    output logic [CW-1:0]        notify_lines_o,
    output logic                 cfg_err_o
);
    typedef struct packed {
        logic [N_PORTS-1:0][CW-1:0]   ctrl;
        logic [N_PORTS-1:0][PINS-1:0] dat;
        logic [N_PORTS-1:0][PINS-1:0] pdir;
        logic [N_PORTS-1:0][PINS-1:0] pdat;
        logic [PINS-1:0]              icfg;
        logic                         err;
        logic [LISTENERS-1:0]         ntf;
        logic [CW-1:0]                nlines;
    } st_t;

    st_t st_d, st_q;

    logic [N_PORTS-1:0][CW-1:0]   ctrl_d;
    logic [N_PORTS-1:0][PINS-1:0] dat_d, pdir_d, pdat_d;
    logic [N_PORTS-1:0][PINS-1:0] lines_cur, lines_nxt;
    logic [LISTENERS-1:0]            slot_used;
    logic [LISTENERS-1:0][CW-1:0]    slot_mask;

    logic port_hit;
    logic wport;

    assign port_hit = cpu_we && (cpu_addr == ADR_CTRL_A || cpu_addr == ADR_DATA_A ||
                                 cpu_addr == ADR_CTRL_B || cpu_addr == ADR_DATA_B);
    assign wport    = (cpu_addr == ADR_CTRL_B) || (cpu_addr == ADR_DATA_B);

    // next values of the per-port registers
    always_comb begin
        ctrl_d = st_q.ctrl;
        dat_d  = st_q.dat;
        pdir_d = st_q.pdir;
        pdat_d = st_q.pdat;
        if (cpu_we) begin
            case (cpu_addr)
                ADR_CTRL_A: ctrl_d[0] = cpu_wdata;
                ADR_DATA_A: dat_d[0]  = cpu_wdata[PINS-1:0];
                ADR_CTRL_B: ctrl_d[1] = cpu_wdata;
                ADR_DATA_B: dat_d[1]  = cpu_wdata[PINS-1:0];
                default: ;
            endcase
        end
        if (per_we) begin
            pdir_d[per_sel] = per_dir;
            pdat_d[per_sel] = per_data;
        end
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        logic [PINS-1:0] dir_c, pull_c, dir_n, pull_n;
        logic [PINS-1:0] lc, ln;

        gpio_ctrl_unpack #(.PINS(PINS)) u_unp_cur (
            .ctrl_i(st_q.ctrl[p]), .dir_o(dir_c), .pull_o(pull_c));
        gpio_ctrl_unpack #(.PINS(PINS)) u_unp_nxt (
            .ctrl_i(ctrl_d[p]), .dir_o(dir_n), .pull_o(pull_n));

        gpio_line_resolve #(.PINS(PINS)) u_res_cur (
            .cpu_dir_i(dir_c), .cpu_dat_i(st_q.dat[p]),
            .per_dir_i(st_q.pdir[p]), .per_dat_i(st_q.pdat[p]),
            .pull_i(pull_c), .lines_o(lc));
        gpio_line_resolve #(.PINS(PINS)) u_res_nxt (
            .cpu_dir_i(dir_n), .cpu_dat_i(dat_d[p]),
            .per_dir_i(pdir_d[p]), .per_dat_i(pdat_d[p]),
            .pull_i(pull_n), .lines_o(ln));

        assign lines_cur[p] = lc;
        assign lines_nxt[p] = ln;
    end

    gpio_listener_table #(.SLOTS(LISTENERS), .MASKW(CW)) u_tbl (
        .clk(clk), .rst_n(rst_n), .req_i(reg_req), .mask_i(reg_mask),
        .grant_o(reg_grant), .slot_o(reg_slot),
        .used_o(slot_used), .mask_o(slot_mask));

    always_comb begin
        logic [PINS-1:0] changed;
        logic [PINS-1:0] half;
        st_d        = st_q;
        st_d.ctrl   = ctrl_d;
        st_d.dat    = dat_d;
        st_d.pdir   = pdir_d;
        st_d.pdat   = pdat_d;
        st_d.ntf    = '0;
        changed     = lines_cur[wport] ^ lines_nxt[wport];
        for (int k = 0; k < LISTENERS; k++) begin
            half = wport ? slot_mask[k][CW-1:PINS] : slot_mask[k][PINS-1:0];
            st_d.ntf[k] = port_hit && slot_used[k] && (|(half & changed));
        end
        if (port_hit) st_d.nlines = {lines_nxt[1], lines_nxt[0]};
        if (cpu_we && cpu_addr == ADR_ICFG) begin
            st_d.icfg = cpu_wdata[PINS-1:0];
            if (|cpu_wdata[PINS-1:0]) st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (cpu_addr)
            ADR_CTRL_A: cpu_rdata = st_q.ctrl[0];
            ADR_DATA_A: cpu_rdata = {{(CW-PINS){1'b0}}, lines_cur[0]};
            ADR_CTRL_B: cpu_rdata = st_q.ctrl[1];
            ADR_DATA_B: cpu_rdata = {{(CW-PINS){1'b0}}, lines_cur[1]};
            ADR_ICFG:   cpu_rdata = {{(CW-PINS){1'b0}}, st_q.icfg};
            default:    cpu_rdata = '0;
        endcase
    end

    assign lines_o        = {lines_cur[1], lines_cur[0]};
    assign notify_o       = st_q.ntf;
    assign notify_lines_o = st_q.nlines;
    assign cfg_err_o      = st_q.err;
endmodule

// File: rtl/dualport_gpio_chk.sv
module dualport_gpio_chk #(
    parameter int unsigned PINS      = 16,
    parameter int unsigned LISTENERS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cpu_we,
    input logic [2:0]           cpu_addr,
    input logic [2*PINS-1:0]    cpu_wdata,
    input logic                 reg_req,
    input logic                 reg_grant,
    input logic [LISTENERS-1:0] slot_used,
    input logic [LISTENERS-1:0] notify_o,
    input logic [2*PINS-1:0]    notify_lines_o,
    input logic [2*PINS-1:0]    lines_o,
    input logic                 cfg_err_o
);
    p_notify_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|notify_o) |-> ($past(cpu_we) && ($past(cpu_addr) < 3'd4)));

    p_notify_lines_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|notify_o) |-> (notify_lines_o == lines_o));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> cfg_err_o);

    p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == 3'd4 && (|cpu_wdata[PINS-1:0])) |=> cfg_err_o);

    p_full_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && (&slot_used)) |-> !reg_grant);
endmodule

bind dualport_gpio dualport_gpio_chk #(.PINS(PINS), .LISTENERS(LISTENERS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .reg_req(reg_req), .reg_grant(reg_grant),
    .slot_used(slot_used), .notify_o(notify_o), .notify_lines_o(notify_lines_o),
    .lines_o(lines_o), .cfg_err_o(cfg_err_o));

// File: tb/sim_dualport_gpio.sv
module sim_dualport_gpio;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [2:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        per_we = 1'b0;
    logic        per_sel = 1'b0;
    logic [15:0] per_dir = '0;
    logic [15:0] per_data = '0;
    logic        reg_req = 1'b0;
    logic [31:0] reg_mask = '0;
    logic        reg_grant;
    logic [1:0]  reg_slot;
    logic [31:0] lines_o;
    logic [3:0]  notify_o;
    logic [31:0] notify_lines_o;
    logic        cfg_err_o;

    dualport_gpio u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model
    logic [31:0] m_ctrl [2];
    logic [15:0] m_dat [2], m_pdir [2], m_pdat [2];
    logic [31:0] m_mask [4];
    bit          m_used [4];

    function automatic logic [15:0] m_lines(int p);
        logic [15:0] d, u;
        for (int n = 0; n < 16; n++) begin
            d[n] = m_ctrl[p][2*n];
            u[n] = m_ctrl[p][2*n+1];
        end
        return (d & m_dat[p]) | (m_pdir[p] & m_pdat[p]) | (~(d | m_pdir[p]) & u);
    endfunction

    typedef struct { int due; logic [3:0] ntf; logic [31:0] lines; string req; } exp_t;
    exp_t sb[$];

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t it;
                it = sb.pop_front();
                chk(notify_o == it.ntf, it.req, {28'd0, notify_o}, {28'd0, it.ntf});
                if (it.ntf != 0)
                    chk(notify_lines_o == it.lines, "R5 lines", notify_lines_o, it.lines);
            end else if (notify_o != 0) begin
                chk(1'b0, "R4 unexpected notify", {28'd0, notify_o}, 32'd0);
            end
        end
    end

    task automatic cpu_write(logic [2:0] a, logic [31:0] v, string req);
        int p;
        logic [15:0] old_l, new_l, chg, half;
        exp_t it;
        @(negedge clk);
        if (a <= 3'd3) begin
            p = (a >= 3'd2) ? 1 : 0;
            old_l = m_lines(p);
            if (a[0] == 1'b0) m_ctrl[p] = v; else m_dat[p] = v[15:0];
            new_l = m_lines(p);
            chg = old_l ^ new_l;
            it.ntf = '0;
            for (int k = 0; k < 4; k++) begin
                half = p ? m_mask[k][31:16] : m_mask[k][15:0];
                it.ntf[k] = m_used[k] && ((half & chg) != 0);
            end
            it.due = cyc + 1;
            it.lines = {m_lines(1), m_lines(0)};
            it.req = req;
            sb.push_back(it);
        end
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = v;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic per_write(logic s, logic [15:0] d, logic [15:0] v);
        @(negedge clk);
        m_pdir[s] = d; m_pdat[s] = v;
        per_we = 1'b1; per_sel = s; per_dir = d; per_data = v;
        @(negedge clk);
        per_we = 1'b0;
        chk(notify_o == 4'd0, "R9 no notify on peripheral update", {28'd0, notify_o}, 32'd0);
    endtask

    task automatic reg_listener(logic [31:0] m, bit exp_g, logic [1:0] exp_s);
        @(negedge clk);
        reg_req = 1'b1; reg_mask = m;
        #1;
        chk(reg_grant == exp_g, "R6 grant", {31'd0, reg_grant}, {31'd0, exp_g});
        if (exp_g) begin
            chk(reg_slot == exp_s, "R6 slot", {30'd0, reg_slot}, {30'd0, exp_s});
            m_used[exp_s] = 1'b1; m_mask[exp_s] = m;
        end
        @(negedge clk);
        reg_req = 1'b0;
    endtask

    task automatic read_chk(logic [2:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        cpu_addr = a;
        #1;
        chk(cpu_rdata == exp, req, cpu_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            m_ctrl[p] = '0; m_dat[p] = '0; m_pdir[p] = '0; m_pdat[p] = '0;
        end
        for (int k = 0; k < 4; k++) begin m_used[k] = 0; m_mask[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(lines_o == 32'd0, "R8 lines after reset", lines_o, 32'd0);
        chk(cfg_err_o == 1'b0, "R8 err after reset", {31'd0, cfg_err_o}, 32'd0);
        read_chk(3'd0, 32'd0, "R8 ctrl A after reset");

        // R6 listeners
        reg_listener(32'h0000_000F, 1, 2'd0);
        reg_listener(32'hFF00_0000, 1, 2'd1);
        reg_listener(32'h0000_F000, 1, 2'd2);
        reg_listener(32'hFFFF_FFFF, 1, 2'd3);
        reg_listener(32'h1234_5678, 0, 2'd0);

        // R1: all odd bits -> pull-ups on every pin of port A
        cpu_write(3'd0, 32'hAAAA_AAAA, "R1 pull-up enable notify");
        chk(lines_o == 32'h0000_FFFF, "R1 pull-ups raise A", lines_o, 32'h0000_FFFF);

        // R4: data write with no drive enabled leaves levels unchanged
        cpu_write(3'd1, 32'h0000_1234, "R4 unchanged levels");
        read_chk(3'd1, 32'h0000_FFFF, "R3 data read returns levels");

        // R1: all even bits -> CPU drives every pin, pull-ups off
        cpu_write(3'd0, 32'h5555_5555, "R1 direction enable notify");
        chk(lines_o == 32'h0000_1234, "R1 drive shows data", lines_o, 32'h0000_1234);
        read_chk(3'd0, 32'h5555_5555, "R3 ctrl read returns word");

        // R5: single-pin change hits only overlapping masks (slots 0 and 3)
        cpu_write(3'd1, 32'h0000_1230, "R5 mask filter port A");

        // R2 / R9: peripheral drive on port B
        per_write(1'b1, 16'hFFFF, 16'h00F0);
        chk(lines_o == 32'h00F0_1230, "R2 peripheral drive B", lines_o, 32'h00F0_1230);
        cpu_write(3'd2, 32'h8000_0000, "R4 pull-up masked by drive");
        per_write(1'b1, 16'h0000, 16'h0000);
        chk(lines_o[31:16] == 16'h8000, "R2 pull-up when undriven", {16'd0, lines_o[31:16]}, 32'h8000);
        cpu_write(3'd2, 32'h4000_0000, "R5 port B masks");
        chk(lines_o[31:16] == 16'h0000, "R2 cpu drive low over pull-up", {16'd0, lines_o[31:16]}, 32'd0);

        // R2: CPU and peripheral drive merge by OR
        per_write(1'b0, 16'h00FF, 16'h000F);
        chk(lines_o[15:0] == 16'h123F, "R2 merged drive A", {16'd0, lines_o[15:0]}, 32'h123F);
        read_chk(3'd3, 32'h0000_0000, "R3 data read B");

        // R7 configuration error
        cpu_write(3'd4, 32'h0, "R7 zero write");
        @(negedge clk);
        chk(cfg_err_o == 1'b0, "R7 zero write no error", {31'd0, cfg_err_o}, 32'd0);
        cpu_write(3'd4, 32'h5, "R7 nonzero write");
        chk(cfg_err_o == 1'b1, "R7 error set", {31'd0, cfg_err_o}, 32'd1);
        cpu_write(3'd4, 32'h0, "R7 zero after error");
        repeat (2) @(negedge clk);
        chk(cfg_err_o == 1'b1, "R7 error sticky", {31'd0, cfg_err_o}, 32'd1);

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R5 scoreboard drained", sb.size(), 32'd0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule